// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Registers

This block holds the command and event register pair of a hot-plug capable downstream port. Software reaches both through a single 32-bit configuration dword with four byte enables: the control half sits in the low 16 bits and the status half in bits 23:16. Every write that touches either control byte counts as one command. The block applies the command, and posts a command-completed event on the same clock edge.

The stored control fields drive the attention indicator, the power indicator and the power controller directly. The electromechanical lock follows a status bit that toggles each time software writes 1 to the lock-control bit. Card insertion, card removal and attention-button presses arrive as single-cycle pulses. They set write-1-to-clear event bits, and an interrupt request is raised while any enabled event is pending. A write that switches off both the slot power and the power indicator on an occupied slot is treated as a safe detach, and clears presence.

Top module: `hp_slot_regs`

## Requirements
- R1: After reset the control half reads with every event enable (bits 5:0) at 0, the attention indicator field (bits 7:6) at Off (2'b11), and bits 15:11 at 0. The indicator encoding is 01 On, 10 Blink, 11 Off.
- R2: With a power controller fitted, reset leaves the power controller field (bit 10, 1 = power off) at 0 and the power indicator (bits 9:8) at On when `strap_populated` is 1. When `strap_populated` is 0, reset sets bit 10 to 1 and the power indicator to Off.
- R3: After reset these status bits are 0: lock engaged (bit 23), command completed (bit 20), presence changed (bit 19) and button pressed (bit 16). Presence state (bit 22) equals `strap_populated`.
- R4: A write with byte enable 1 and data bit 11 set inverts the lock status (bit 23, also `lock_engaged`) on that edge. Bit 11 always reads 0.
- R5: A write with byte enable 0 or 1 set updates only the control bytes that are enabled. It sets command completed (bit 20) on the same edge.
- R6: If presence state is 1 and a write with byte enable 1 carries bit 10 = 1 and bits 9:8 = 2'b11, presence state clears and presence changed sets.
- R7: An `insert_req` pulse is ignored while the lock is engaged. Otherwise it sets presence state and presence changed. A `remove_req` pulse clears presence state and sets presence changed. A safe detach outranks insertion, and insertion outranks removal.
- R8: Bits 20:16 are write-1-to-clear under byte enable 2. An event that is raised in the same cycle as its clear stays set.
- R9: A `btn_press` pulse sets button pressed (bit 16).
- R10: `irq` = bit5 AND ((bit19 AND bit3) OR (bit16 AND bit0) OR (bit20 AND bit4)). `attn_ind`, `pwr_ind` and `pwr_off` mirror bits 7:6, 9:8 and 10.
- R11: Status writes cannot alter presence state (bit 22), lock status (bit 23) or bit 21. Bits 31:24 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_populated | input | 1 | Slot occupancy sampled during reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_be | input | 4 | Byte enables of the write |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_data | output | 32 | Current register dword |
| insert_req | input | 1 | Card insertion pulse |
| remove_req | input | 1 | Card removal pulse |
| btn_press | input | 1 | Attention button pulse |
| attn_ind | output | 2 | Attention indicator state |
| pwr_ind | output | 2 | Power indicator state |
| pwr_off | output | 1 | Power controller off request |
| lock_engaged | output | 1 | Electromechanical lock drive |
| irq | output | 1 | Hot-plug interrupt request |

## Verification
The sharpest collision is between a command write raising command completed and a write-1-to-clear of that same bit. A presence-changed clear colliding with an insertion, removal or safe detach is the same kind of case. Both are provoked by single dword writes with byte enables 0 to 2 all set, and by random writes issued while random hot-plug pulses fire. The bench judges every cycle against its own model, in which a set always outranks a clear. Insertion pulses that arrive while the lock toggles in the same write are also compared against the lock state held before that edge.

// File: rtl/hp_slot_pkg.sv
// Shared field positions and encodings of the slot register pair.
// Assumes the control half is 11 stored bits and the status half is 8 bits.
package hp_slot_pkg;
    localparam int CTL_W = 11;
    localparam int STS_W = 8;

    // control field positions
    localparam int C_ABPE  = 0;
    localparam int C_PFDE  = 1;
    localparam int C_MRLE  = 2;
    localparam int C_PDCE  = 3;
    localparam int C_CCIE  = 4;
    localparam int C_HPIE  = 5;
    localparam int C_AIC   = 6;
    localparam int C_PIC   = 8;
    localparam int C_PCC   = 10;
    localparam int C_EIC   = 11;

    // status field positions
    localparam int S_ABP   = 0;
    localparam int S_PFD   = 1;
    localparam int S_MRLC  = 2;
    localparam int S_PDC   = 3;
    localparam int S_CC    = 4;
    localparam int S_MRLS  = 5;
    localparam int S_PDS   = 6;
    localparam int S_EIS   = 7;

    localparam logic [STS_W-1:0] W1C_MASK = 8'b0001_1111;

    localparam logic [1:0] IND_ON    = 2'b01;
    localparam logic [1:0] IND_BLINK = 2'b10;
    localparam logic [1:0] IND_OFF   = 2'b11;
endpackage

// File: rtl/hp_slot_ctl.sv
// Control half: stores the writable command fields under byte enables and
// decodes each write into command, lock-toggle and safe-detach strobes.
// Assumes one write per cycle; lock-control bit is never stored.
module hp_slot_ctl
    import hp_slot_pkg::*;
#(
    parameter bit PWR_CTRL_PRESENT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_populated,
    input  logic             wr_en,
    input  logic [1:0]       wr_be,
    input  logic [11:0]      wr_data,
    input  logic             pds,
    output logic [CTL_W-1:0] ctl_q,
    output logic             cmd_stb,
    output logic             eic_tgl,
    output logic             detach_req
);
    localparam logic [CTL_W-1:0] WMASK = PWR_CTRL_PRESENT ? 11'h7FF : 11'h3FF;

    logic [1:0]       rst_pic;
    logic             rst_pcc;
    logic [CTL_W-1:0] rst_val;
    logic [CTL_W-1:0] lane;
    logic [CTL_W-1:0] ctl_nxt;

    // reset values of the power fields depend on whether a controller exists
    generate
        if (PWR_CTRL_PRESENT) begin : g_pwr
            assign rst_pic = strap_populated ? IND_ON : IND_OFF;
            assign rst_pcc = ~strap_populated;
        end else begin : g_nopwr
            assign rst_pic = 2'b00;
            assign rst_pcc = 1'b0;
        end
    endgenerate

    assign rst_val = {rst_pcc, rst_pic, IND_OFF, 6'b000000};
    assign lane    = {{3{wr_be[1]}}, {8{wr_be[0]}}} & WMASK;

    // command strobes decoded from the raw write
    assign cmd_stb    = wr_en & (|wr_be);
    assign eic_tgl    = wr_en & wr_be[1] & wr_data[C_EIC];
    assign detach_req = wr_en & wr_be[1] & wr_data[C_PCC] &
                        (wr_data[C_PIC+1:C_PIC] == IND_OFF) & pds;

    // merge enabled lanes into the stored fields
    always_comb begin
        ctl_nxt = ctl_q;
        if (wr_en) ctl_nxt = (ctl_q & ~lane) | (wr_data[CTL_W-1:0] & lane);
    end

    // control register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= rst_val;
        else        ctl_q <= ctl_nxt;
    end

    p_detach_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        detach_req |=> ctl_q[C_PCC] && (ctl_q[C_PIC+1:C_PIC] == IND_OFF));
    p_no_write_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctl_q));
endmodule

// File: rtl/hp_slot_sts.sv
// Status half: presence, lock and write-1-to-clear event bits.
// Assumes hot-plug pulses last one cycle; a set beats a clear of the same bit.
module hp_slot_sts
    import hp_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_populated,
    input  logic             cmd_stb,
    input  logic             eic_tgl,
    input  logic             detach_req,
    input  logic             insert_req,
    input  logic             remove_req,
    input  logic             btn_press,
    input  logic             w1c_en,
    input  logic [STS_W-1:0] w1c_data,
    output logic [STS_W-1:0] sts_q
);
    logic             ins_ok;
    logic [STS_W-1:0] evt_set;
    logic [STS_W-1:0] evt_clr;
    logic [STS_W-1:0] sts_nxt;

    assign ins_ok = insert_req & ~sts_q[S_EIS];

    // event sources and clears
    always_comb begin
        evt_set          = '0;
        evt_set[S_ABP]   = btn_press;
        evt_set[S_PDC]   = detach_req | ins_ok | remove_req;
        evt_set[S_CC]    = cmd_stb;
        evt_clr          = w1c_en ? (w1c_data & W1C_MASK) : '0;
    end

    // next status: events, presence priority and lock toggle
    always_comb begin
        sts_nxt = (sts_q & ~evt_clr) | evt_set;
        if (detach_req)      sts_nxt[S_PDS] = 1'b0;
        else if (ins_ok)     sts_nxt[S_PDS] = 1'b1;
        else if (remove_req) sts_nxt[S_PDS] = 1'b0;
        sts_nxt[S_EIS] = sts_q[S_EIS] ^ eic_tgl;
    end

    // status register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q        <= '0;
            sts_q[S_PDS] <= strap_populated;
        end else begin
            sts_q <= sts_nxt;
        end
    end

    p_lock_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eic_tgl |=> sts_q[S_EIS] != $past(sts_q[S_EIS]));
    p_locked_insert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        insert_req && sts_q[S_EIS] && !remove_req && !detach_req |=> $stable(sts_q[S_PDS]));
    p_w1c_pdc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        w1c_en && w1c_data[S_PDC] && !detach_req && !insert_req && !remove_req |=> !sts_q[S_PDC]);
    p_detach_pres_r6: assert property (@(posedge clk) disable iff (!rst_n)
        detach_req |=> !sts_q[S_PDS] && sts_q[S_PDC]);
    p_button_r9: assert property (@(posedge clk) disable iff (!rst_n)
        btn_press |=> sts_q[S_ABP]);
endmodule

// File: rtl/hp_slot_regs.sv
// Top: joins the control and status halves into one configuration dword,
// drives the slot outputs and the interrupt request.
// Assumes control in bits 15:0 and status in bits 23:16 of the dword.
module hp_slot_regs
    import hp_slot_pkg::*;
#(
    parameter bit PWR_CTRL_PRESENT = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strap_populated,
    input  logic        cfg_wr_en,
    input  logic [3:0]  cfg_wr_be,
    input  logic [31:0] cfg_wr_data,
    output logic [31:0] cfg_rd_data,
    input  logic        insert_req,
    input  logic        remove_req,
    input  logic        btn_press,
    output logic [1:0]  attn_ind,
    output logic [1:0]  pwr_ind,
    output logic        pwr_off,
    output logic        lock_engaged,
    output logic        irq
);
    localparam int STS_LO = 16;

    logic [CTL_W-1:0] ctl_q;
    logic [STS_W-1:0] sts_q;
    logic             cmd_stb, eic_tgl, detach_req;
    logic             unused_wbits;

    assign unused_wbits = ^{cfg_wr_be[3], cfg_wr_data[31:24], cfg_wr_data[15:12]};

    hp_slot_ctl #(.PWR_CTRL_PRESENT(PWR_CTRL_PRESENT)) u_ctl (
        .clk             (clk),
        .rst_n           (rst_n),
        .strap_populated (strap_populated),
        .wr_en           (cfg_wr_en),
        .wr_be           (cfg_wr_be[1:0]),
        .wr_data         (cfg_wr_data[11:0]),
        .pds             (sts_q[S_PDS]),
        .ctl_q           (ctl_q),
        .cmd_stb         (cmd_stb),
        .eic_tgl         (eic_tgl),
        .detach_req      (detach_req)
    );

    hp_slot_sts u_sts (
        .clk             (clk),
        .rst_n           (rst_n),
        .strap_populated (strap_populated),
        .cmd_stb         (cmd_stb),
        .eic_tgl         (eic_tgl),
        .detach_req      (detach_req),
        .insert_req      (insert_req),
        .remove_req      (remove_req),
        .btn_press       (btn_press),
        .w1c_en          (cfg_wr_en & cfg_wr_be[2]),
        .w1c_data        (cfg_wr_data[STS_LO+STS_W-1:STS_LO]),
        .sts_q           (sts_q)
    );

    // read view and slot outputs
    assign cfg_rd_data  = {8'h00, sts_q, 5'b00000, ctl_q};
    assign attn_ind     = ctl_q[C_AIC+1:C_AIC];
    assign pwr_ind      = ctl_q[C_PIC+1:C_PIC];
    assign pwr_off      = ctl_q[C_PCC];
    assign lock_engaged = sts_q[S_EIS];
    assign irq = ctl_q[C_HPIE] & ((sts_q[S_PDC] & ctl_q[C_PDCE]) |
                                  (sts_q[S_ABP] & ctl_q[C_ABPE]) |
                                  (sts_q[S_CC]  & ctl_q[C_CCIE]));

    p_cmd_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en && (|cfg_wr_be[1:0]) |=> cfg_rd_data[STS_LO+S_CC]);
    p_eic_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en && cfg_wr_be[1] && cfg_wr_data[11] |=> !cfg_rd_data[11]);
    p_status_ro_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en && (cfg_wr_be[1:0] == 2'b00) && !insert_req && !remove_req
        |=> $stable(cfg_rd_data[STS_LO+S_PDS]) && $stable(lock_engaged));
endmodule

// File: tb/tb_hp_slot_regs.sv
`timescale 1ns/1ps
module tb_hp_slot_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_populated = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_wr_be = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic        insert_req = 1'b0, remove_req = 1'b0, btn_press = 1'b0;
    logic [1:0]  attn_ind, pwr_ind;
    logic        pwr_off, lock_engaged, irq;

    int tests = 0;
    int fails = 0;
    logic [10:0] m_ctl;
    logic [7:0]  m_sts;

    always #2 clk = ~clk;

    hp_slot_regs dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd();
        return {8'h00, m_sts, 5'b00000, m_ctl};
    endfunction

    function automatic logic exp_irq();
        return m_ctl[5] & ((m_sts[3] & m_ctl[3]) | (m_sts[0] & m_ctl[0]) | (m_sts[4] & m_ctl[4]));
    endfunction

    task automatic check_all(input string tag);
        check({tag, " rd"}, cfg_rd_data, exp_rd());
        check("R10 irq", {31'b0, irq}, {31'b0, exp_irq()});
        check("R10 outputs", {26'b0, attn_ind, pwr_ind, pwr_off, lock_engaged},
              {26'b0, m_ctl[7:6], m_ctl[9:8], m_ctl[10], m_sts[7]});
    endtask

    // model of one clock edge, written from the requirements
    task automatic model_step(input logic wr, input logic [3:0] be, input logic [31:0] wd,
                              input logic ins, input logic rem, input logic btn);
        logic [10:0] lane;
        logic cmd, eic, det, ok;
        logic [7:0] s;
        lane = {{3{be[1]}}, {8{be[0]}}};
        cmd  = wr & (be[0] | be[1]);
        eic  = wr & be[1] & wd[11];
        det  = wr & be[1] & wd[10] & (wd[9:8] == 2'b11) & m_sts[6];
        ok   = ins & ~m_sts[7];
        s = m_sts;
        if (wr && be[2]) s = s & ~(wd[23:16] & 8'h1F);
        if (btn) s[0] = 1'b1;
        if (det | ok | rem) s[3] = 1'b1;
        if (cmd) s[4] = 1'b1;
        if (det) s[6] = 1'b0; else if (ok) s[6] = 1'b1; else if (rem) s[6] = 1'b0;
        s[7] = m_sts[7] ^ eic;
        if (wr) m_ctl = (m_ctl & ~lane) | (wd[10:0] & lane);
        m_sts = s;
    endtask

    task automatic op(input string tag, input logic wr, input logic [3:0] be, input logic [31:0] wd,
                      input logic ins, input logic rem, input logic btn);
        cfg_wr_en = wr; cfg_wr_be = be; cfg_wr_data = wd;
        insert_req = ins; remove_req = rem; btn_press = btn;
        model_step(wr, be, wd, ins, rem, btn);
        @(negedge clk);
        cfg_wr_en = 1'b0; insert_req = 1'b0; remove_req = 1'b0; btn_press = 1'b0;
        check_all(tag);
    endtask

    task automatic do_reset(input logic strap);
        rst_n = 1'b0; strap_populated = strap;
        @(negedge clk);
        rst_n = 1'b1;
        m_ctl = strap ? 11'h1C0 : 11'h7C0;
        m_sts = {1'b0, strap, 6'b0};
        check_all("R1 R2 R3 reset");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset(1'b1);
        check("R2 populated ctl", cfg_rd_data, 32'h0040_01C0);
        check("R3 populated pres", {31'b0, cfg_rd_data[22]}, 32'd1);
        do_reset(1'b0);
        check("R2 empty ctl", cfg_rd_data, 32'h0000_07C0);
        check("R1 attn off", {30'b0, attn_ind}, 32'd3);

        // R4: lock toggle, bit reads 0
        op("R4 lock on", 1'b1, 4'b0010, 32'h0000_0800, 1'b0, 1'b0, 1'b0);
        check("R4 lock engaged", {31'b0, lock_engaged}, 32'd1);
        check("R4 eic reads 0", {31'b0, cfg_rd_data[11]}, 32'd0);
        // R7: insertion refused while locked
        op("R7 locked insert", 1'b0, 4'b0000, 32'h0, 1'b1, 1'b0, 1'b0);
        check("R7 presence held", {31'b0, cfg_rd_data[22]}, 32'd0);
        op("R4 lock off", 1'b1, 4'b0010, 32'h0000_0800, 1'b0, 1'b0, 1'b0);
        op("R7 insert", 1'b0, 4'b0000, 32'h0, 1'b1, 1'b0, 1'b0);
        check("R7 presence set", {31'b0, cfg_rd_data[22]}, 32'd1);
        // R8: clear all events, then collision of CC clear and command
        op("R8 clear", 1'b1, 4'b0100, 32'h001F_0000, 1'b0, 1'b0, 1'b0);
        check("R8 events clear", {24'b0, cfg_rd_data[23:16] & 8'h1F}, 32'd0);
        op("R8 set beats clear", 1'b1, 4'b0101, 32'h0010_0000, 1'b0, 1'b0, 1'b0);
        check("R8 cc kept", {31'b0, cfg_rd_data[20]}, 32'd1);
        // R6: safe detach on populated slot
        op("R6 detach", 1'b1, 4'b0010, 32'h0000_0700, 1'b0, 1'b0, 1'b0);
        check("R6 pres cleared", {30'b0, cfg_rd_data[22], cfg_rd_data[19]}, 32'd1);
        // R10/R9: button with enables
        op("R9 enables", 1'b1, 4'b0101, 32'h001F_0021, 1'b0, 1'b0, 1'b0);
        op("R9 button", 1'b0, 4'b0000, 32'h0, 1'b0, 1'b0, 1'b1);
        check("R10 irq on button", {31'b0, irq}, 32'd1);
        // R11: status write cannot touch presence or lock
        op("R11 ro status", 1'b1, 4'b1100, 32'hFFFF_0000, 1'b0, 1'b0, 1'b0);
        check("R11 upper zero", {24'b0, cfg_rd_data[31:24]}, 32'd0);

        // R5 and mixed collisions under random stimulus
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] wd;
            logic [3:0]  be;
            wd = $urandom();
            be = 4'($urandom());
            if (($urandom() % 4) != 0) wd[11] = 1'b0;
            op("R5 random", ($urandom() % 2) == 0, be, wd,
               ($urandom() % 5) == 0, ($urandom() % 7) == 0, ($urandom() % 6) == 0);
            if ((i % 500) == 499) do_reset(i[9]);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule